// File: doc/BRIEF.md
# Sparse Control Escape Sequencer

This unit holds the control state of a data-driven processor. The address sequencer steps through memory and the reconfigurable datapath works on the words it fetches. Neither action changes control state. The unit tracks the running scan and watches the tagged word stream and four status flags. When one or more escape sources fire, it ends the scan and records why. It then updates its three state registers: the scan pattern select with its parameter, the operator subnet select, and the residual control state.

Three escapes need help from outside: off-limits, branch and event. For these the unit stops, asks a separate memory segment for a remote word over a valid/ready request, and waits for the reply. A reply tagged as a control word is decoded into the state registers. A reply tagged as an address word puts the unit in list mode. A tagged address word in the data stream also turns on list mode, and the scan keeps running. When the selected scan pattern is data-dependent, only a branch or an off-limits condition can end the scan.

Top module: `resid_escape_unit`

## Requirements
- R1: While reset is held and just after it ends, the unit is idle. Scan select, parameter, operator select, residual state, list mode, list address and cause are all zero. `rf_valid` and `rsp_ready` are low.
- R2: `scan_start` in the idle state raises `scan_active` on the next cycle and clears `esc_cause` to 0. It has no effect in any other state.
- R3: In a running scan that is not data-dependent, `eos_flag` with no other source ends the scan on the next cycle, with cause 1. The state registers do not change.
- R4: A valid word tagged 01 (control word) ends a running scan that is not data-dependent, with cause 2. Its data is decoded, with F = DATA_W/4: bits [4F-1:3F] go to residual state, [3F-1:2F] to pattern select, [2F-1:F] to operator select and [F-1:0] to pattern parameter. List mode is cleared.
- R5: A valid word tagged 10 (address word) during a scan sets `list_mode` and loads `list_addr` from data bits [ADDR_W-1:0]. The scan goes on. Tags 00 (data) and 11 (reserved) change nothing.
- R6: When several sources fire in one cycle, one escape is taken. The order is event (cause 5), then off-limits (3), then branch (4), then control word (2), then end-of-scan (1).
- R7: Event, off-limits and branch escapes raise `rf_valid` on the next cycle. `rf_addr` is the residual state followed by the 3-bit cause, zero-extended. Both hold until `rf_ready` is seen.
- R8: After the request is accepted, `rsp_ready` is high until `rsp_valid` arrives. A reply tagged 01 is decoded as in R4. A reply tagged 10 sets list mode and loads `list_addr` from `rsp_data[ADDR_W-1:0]`. Other tags change nothing. The unit then goes idle. The scan stays halted from the escape until the reply is taken.
- R9: When the pattern select MSB is 1 (data-dependent scan), event, control word and end-of-scan are ignored. Only off-limits or branch ends the scan.
- R10: `esc_cause` holds from the escape until the next accepted `scan_start`. Pattern select, parameter, operator select and residual state change only on a decoded control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_start | input | 1 | Begin a scan when idle |
| word_valid | input | 1 | Cache word present this cycle |
| word_tag | input | 2 | Word tag: 00 data, 01 control, 10 address, 11 reserved |
| word_data | input | DATA_W | Cache word payload |
| eos_flag | input | 1 | End of scan from address sequencer |
| off_limits | input | 1 | Address left segment bounds |
| branch_dec | input | 1 | Branch decision from datapath |
| event_flag | input | 1 | External event |
| rf_valid | output | 1 | Remote fetch request valid |
| rf_ready | input | 1 | Remote fetch request accepted |
| rf_addr | output | ADDR_W | Remote word address |
| rsp_valid | input | 1 | Remote word returned |
| rsp_ready | output | 1 | Unit waits for remote word |
| rsp_tag | input | 2 | Tag of remote word |
| rsp_data | input | DATA_W | Remote word payload |
| scan_active | output | 1 | Scan running |
| pat_sel | output | DATA_W/4 | Scan pattern select (MSB: data-dependent) |
| pat_param | output | DATA_W/4 | Scan pattern parameter |
| op_sel | output | DATA_W/4 | Operator subnet select |
| res_state | output | DATA_W/4 | Residual control state |
| list_mode | output | 1 | Next address taken from list |
| list_addr | output | ADDR_W | List-mode next address |
| esc_cause | output | 3 | Last escape cause, 0 = none |

## Verification
Some properties are checked on every cycle. At most one of scan, request and wait is active at a time. A pending request keeps its address stable. A data-dependent scan survives every source other than branch and off-limits. An event always takes priority. The cause is held between scans. The state registers move only after a decoded control word. The bench scenarios cover the rest. They check the decoded field values and the exact priority result when all sources fire together. They check list-address loading from both the stream and a remote reply. They also check that reserved and data tags have no effect, with directed and seeded random stimulus compared against a cycle model.

// File: rtl/esc_pkg.sv
package esc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_REQ  = 2'd2,
      ST_WAIT = 2'd3
   } esc_state_e;

   typedef enum logic [2:0] {
      CA_NONE   = 3'd0,
      CA_NORMAL = 3'd1,
      CA_DELIM  = 3'd2,
      CA_OFFLIM = 3'd3,
      CA_BRANCH = 3'd4,
      CA_EVENT  = 3'd5
   } esc_cause_e;

   localparam logic [1:0] TAG_DATA = 2'b00;
   localparam logic [1:0] TAG_CTRL = 2'b01;
   localparam logic [1:0] TAG_ADDR = 2'b10;
   localparam logic [1:0] TAG_RSVD = 2'b11;

   // source slots, lowest index wins
   localparam int SRC_EVENT  = 0;
   localparam int SRC_OFFLIM = 1;
   localparam int SRC_BRANCH = 2;
   localparam int SRC_DELIM  = 3;
   localparam int SRC_NORMAL = 4;
   localparam int NUM_SRC    = 5;
   localparam int CAUSE_W    = 3;
endpackage

// File: rtl/esc_prio.sv
module esc_prio #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   logic [N:0] blocked;
   assign blocked[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]     = req[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | req[i];
   end
endmodule

// File: rtl/esc_state_regs.sv
module esc_state_regs #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld_ctrl,
   input  logic [DATA_W-1:0]   ctrl_word,
   input  logic                ld_list,
   input  logic [ADDR_W-1:0]   list_word,
   output logic [DATA_W/4-1:0] pat_sel,
   output logic [DATA_W/4-1:0] pat_param,
   output logic [DATA_W/4-1:0] op_sel,
   output logic [DATA_W/4-1:0] res_state,
   output logic                list_mode,
   output logic [ADDR_W-1:0]   list_addr
);
   localparam int F = DATA_W / 4;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pat_sel   <= '0;
         pat_param <= '0;
         op_sel    <= '0;
         res_state <= '0;
      end else if (ld_ctrl) begin
         res_state <= ctrl_word[4*F-1:3*F];
         pat_sel   <= ctrl_word[3*F-1:2*F];
         op_sel    <= ctrl_word[2*F-1:F];
         pat_param <= ctrl_word[F-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         list_mode <= 1'b0;
         list_addr <= '0;
      end else if (ld_list) begin
         list_mode <= 1'b1;
         list_addr <= list_word;
      end else if (ld_ctrl) begin
         list_mode <= 1'b0;
      end
   end
endmodule

// File: rtl/resid_escape_unit.sv
module resid_escape_unit
   import esc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                scan_start,
   input  logic                word_valid,
   input  logic [1:0]          word_tag,
   input  logic [DATA_W-1:0]   word_data,
   input  logic                eos_flag,
   input  logic                off_limits,
   input  logic                branch_dec,
   input  logic                event_flag,
   output logic                rf_valid,
   input  logic                rf_ready,
   output logic [ADDR_W-1:0]   rf_addr,
   input  logic                rsp_valid,
   output logic                rsp_ready,
   input  logic [1:0]          rsp_tag,
   input  logic [DATA_W-1:0]   rsp_data,
   output logic                scan_active,
   output logic [DATA_W/4-1:0] pat_sel,
   output logic [DATA_W/4-1:0] pat_param,
   output logic [DATA_W/4-1:0] op_sel,
   output logic [DATA_W/4-1:0] res_state,
   output logic                list_mode,
   output logic [ADDR_W-1:0]   list_addr,
   output logic [2:0]          esc_cause
);
   localparam int F     = DATA_W / 4;
   localparam int PAD_W = ADDR_W - F - CAUSE_W;

   if (DATA_W % 4 != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 4 and at least 8");
   end
   if (PAD_W < 0) begin : g_bad_addr_w
      $error("ADDR_W too narrow for residual state plus cause");
   end
   if (ADDR_W > DATA_W) begin : g_bad_list_w
      $error("ADDR_W must not exceed DATA_W");
   end

   esc_state_e  state_q;
   esc_cause_e  cause_q, cause_d;
   logic        in_scan, dd_scan;
   logic [NUM_SRC-1:0] src, grant;
   logic        take_fetch, take_escape;
   logic        ld_ctrl, ld_list;
   logic [DATA_W-1:0] ctrl_word;
   logic [ADDR_W-1:0] list_word;

   assign in_scan = (state_q == ST_SCAN);
   assign dd_scan = pat_sel[F-1];

   // a data-dependent scan masks every exit except branch and off-limits
   always_comb begin
      src             = '0;
      src[SRC_EVENT]  = event_flag & ~dd_scan;
      src[SRC_OFFLIM] = off_limits;
      src[SRC_BRANCH] = branch_dec;
      src[SRC_DELIM]  = word_valid & (word_tag == TAG_CTRL) & ~dd_scan;
      src[SRC_NORMAL] = eos_flag & ~dd_scan;
      if (!in_scan) src = '0;
   end

   esc_prio #(.N(NUM_SRC)) u_prio (
      .req   (src),
      .grant (grant)
   );

   always_comb begin
      cause_d = CA_NONE;
      if      (grant[SRC_EVENT])  cause_d = CA_EVENT;
      else if (grant[SRC_OFFLIM]) cause_d = CA_OFFLIM;
      else if (grant[SRC_BRANCH]) cause_d = CA_BRANCH;
      else if (grant[SRC_DELIM])  cause_d = CA_DELIM;
      else if (grant[SRC_NORMAL]) cause_d = CA_NORMAL;
   end

   assign take_escape = |grant;
   assign take_fetch  = grant[SRC_EVENT] | grant[SRC_OFFLIM] | grant[SRC_BRANCH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cause_q <= CA_NONE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (scan_start) begin
               state_q <= ST_SCAN;
               cause_q <= CA_NONE;
            end
            ST_SCAN: if (take_escape) begin
               cause_q <= cause_d;
               state_q <= take_fetch ? ST_REQ : ST_IDLE;
            end
            ST_REQ:  if (rf_ready)  state_q <= ST_WAIT;
            ST_WAIT: if (rsp_valid) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // register update sources: stream in a scan, or the remote reply
   always_comb begin
      ld_ctrl   = 1'b0;
      ld_list   = 1'b0;
      ctrl_word = word_data;
      list_word = word_data[ADDR_W-1:0];
      if (in_scan) begin
         ld_ctrl = grant[SRC_DELIM];
         ld_list = word_valid & (word_tag == TAG_ADDR);
      end else if (state_q == ST_WAIT && rsp_valid) begin
         ctrl_word = rsp_data;
         list_word = rsp_data[ADDR_W-1:0];
         ld_ctrl   = (rsp_tag == TAG_CTRL);
         ld_list   = (rsp_tag == TAG_ADDR);
      end
   end

   esc_state_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_ctrl   (ld_ctrl),
      .ctrl_word (ctrl_word),
      .ld_list   (ld_list),
      .list_word (list_word),
      .pat_sel   (pat_sel),
      .pat_param (pat_param),
      .op_sel    (op_sel),
      .res_state (res_state),
      .list_mode (list_mode),
      .list_addr (list_addr)
   );

   assign scan_active = in_scan;
   assign rf_valid    = (state_q == ST_REQ);
   assign rsp_ready   = (state_q == ST_WAIT);
   assign esc_cause   = cause_q;

   if (PAD_W > 0) begin : g_pad
      assign rf_addr = {{PAD_W{1'b0}}, res_state, cause_q};
   end else begin : g_nopad
      assign rf_addr = {res_state, cause_q};
   end
endmodule

// File: rtl/resid_escape_chk.sv
module resid_escape_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12
) (
   input logic                clk,
   input logic                rst_n,
   input logic                scan_start,
   input logic                word_valid,
   input logic [1:0]          word_tag,
   input logic                eos_flag,
   input logic                off_limits,
   input logic                branch_dec,
   input logic                event_flag,
   input logic                rf_valid,
   input logic                rf_ready,
   input logic [ADDR_W-1:0]   rf_addr,
   input logic                rsp_valid,
   input logic                rsp_ready,
   input logic [1:0]          rsp_tag,
   input logic                scan_active,
   input logic [DATA_W/4-1:0] pat_sel,
   input logic [DATA_W/4-1:0] pat_param,
   input logic [DATA_W/4-1:0] op_sel,
   input logic [DATA_W/4-1:0] res_state,
   input logic [2:0]          esc_cause
);
   localparam int F = DATA_W / 4;

   a_r8_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({scan_active, rf_valid, rsp_ready}));

   a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      rf_valid && !rf_ready |=> rf_valid && $stable(rf_addr));

   a_r9_dd_survives: assert property (@(posedge clk) disable iff (!rst_n)
      scan_active && pat_sel[F-1] && !off_limits && !branch_dec |=> scan_active);

   a_r6_event_first: assert property (@(posedge clk) disable iff (!rst_n)
      scan_active && event_flag && !pat_sel[F-1] |=> rf_valid && esc_cause == 3'd5);

   a_r3_normal_exit: assert property (@(posedge clk) disable iff (!rst_n)
      scan_active && eos_flag && !pat_sel[F-1] && !event_flag && !off_limits
      && !branch_dec && !(word_valid && word_tag == 2'b01)
      |=> !scan_active && !rf_valid && esc_cause == 3'd1);

   a_r10_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(scan_active) && !$past(scan_start) |-> $stable(esc_cause));

   a_r10_regs_held: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(scan_active && word_valid && word_tag == 2'b01 && !pat_sel[F-1])
      && !$past(rsp_valid && rsp_ready && rsp_tag == 2'b01)
      |-> $stable({pat_sel, pat_param, op_sel, res_state}));
endmodule

bind resid_escape_unit resid_escape_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scan_start  (scan_start),
   .word_valid  (word_valid),
   .word_tag    (word_tag),
   .eos_flag    (eos_flag),
   .off_limits  (off_limits),
   .branch_dec  (branch_dec),
   .event_flag  (event_flag),
   .rf_valid    (rf_valid),
   .rf_ready    (rf_ready),
   .rf_addr     (rf_addr),
   .rsp_valid   (rsp_valid),
   .rsp_ready   (rsp_ready),
   .rsp_tag     (rsp_tag),
   .scan_active (scan_active),
   .pat_sel     (pat_sel),
   .pat_param   (pat_param),
   .op_sel      (op_sel),
   .res_state   (res_state),
   .esc_cause   (esc_cause)
);

// File: tb/resid_escape_unit_tb.sv
module resid_escape_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int AW = 12;
   localparam int F  = DW / 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic          scan_start, word_valid, eos_flag, off_limits, branch_dec, event_flag;
   logic [1:0]    word_tag, rsp_tag;
   logic [DW-1:0] word_data, rsp_data;
   logic          rf_ready, rsp_valid;
   logic          rf_valid, rsp_ready, scan_active, list_mode;
   logic [AW-1:0] rf_addr, list_addr;
   logic [F-1:0]  pat_sel, pat_param, op_sel, res_state;
   logic [2:0]    esc_cause;

   resid_escape_unit #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .scan_start(scan_start),
      .word_valid(word_valid), .word_tag(word_tag), .word_data(word_data),
      .eos_flag(eos_flag), .off_limits(off_limits), .branch_dec(branch_dec),
      .event_flag(event_flag), .rf_valid(rf_valid), .rf_ready(rf_ready),
      .rf_addr(rf_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_tag(rsp_tag), .rsp_data(rsp_data), .scan_active(scan_active),
      .pat_sel(pat_sel), .pat_param(pat_param), .op_sel(op_sel),
      .res_state(res_state), .list_mode(list_mode), .list_addr(list_addr),
      .esc_cause(esc_cause)
   );

   // cycle model built from the requirements
   int            m_st;   // 0 idle, 1 scan, 2 request, 3 wait
   logic [F-1:0]  m_pat, m_prm, m_op, m_res;
   logic          m_list;
   logic [AW-1:0] m_la;
   logic [2:0]    m_cause;

   int    n_chk = 0, n_fail = 0;
   string phase = "";
   bit    done = 0;

   task automatic clr_in();
      scan_start = 0; word_valid = 0; word_tag = 0; word_data = 0;
      eos_flag = 0; off_limits = 0; branch_dec = 0; event_flag = 0;
      rf_ready = 0; rsp_valid = 0; rsp_tag = 0; rsp_data = 0;
   endtask

   function automatic logic [F-1:0] fld(logic [DW-1:0] d, int k);
      return d[k*F +: F];
   endfunction

   task automatic decode(logic [DW-1:0] d);
      m_res = fld(d, 3); m_pat = fld(d, 2); m_op = fld(d, 1); m_prm = fld(d, 0);
      m_list = 1'b0;
   endtask

   task automatic step_model();
      logic dd;
      dd = m_pat[F-1];
      case (m_st)
         0: if (scan_start) begin m_st = 1; m_cause = 0; end
         1: begin
            if (word_valid && word_tag == 2'b10) begin m_list = 1; m_la = word_data[AW-1:0]; end
            if (event_flag && !dd)      begin m_cause = 5; m_st = 2; end
            else if (off_limits)        begin m_cause = 3; m_st = 2; end
            else if (branch_dec)        begin m_cause = 4; m_st = 2; end
            else if (word_valid && word_tag == 2'b01 && !dd) begin
               m_cause = 2; m_st = 0; decode(word_data);
            end
            else if (eos_flag && !dd)   begin m_cause = 1; m_st = 0; end
         end
         2: if (rf_ready) m_st = 3;
         default: if (rsp_valid) begin
            if (rsp_tag == 2'b01) decode(rsp_data);
            else if (rsp_tag == 2'b10) begin m_list = 1; m_la = rsp_data[AW-1:0]; end
            m_st = 0;
         end
      endcase
   endtask

   task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s [%s] actual=%h expected=%h", rq, phase, act, exp);
      end
   endtask

   task automatic check_outs();
      logic [AW-1:0] ea;
      ea = '0;
      ea[F+2:0] = {m_res, m_cause};
      chk("R2",  32'(scan_active), 32'(m_st == 1));
      chk("R7",  {19'd0, rf_valid, rf_addr}, {19'd0, m_st == 2, ea});
      chk("R8",  32'(rsp_ready), 32'(m_st == 3));
      chk("R4",  32'({pat_sel, pat_param, op_sel, res_state}), 32'({m_pat, m_prm, m_op, m_res}));
      chk("R5",  32'({list_mode, list_addr}), 32'({m_list, m_la}));
      chk("R10", 32'(esc_cause), 32'(m_cause));
   endtask

   task automatic cyc();
      step_model();
      @(posedge clk);
      @(negedge clk);
      check_outs();
      clr_in();
   endtask

   task automatic fetch(logic [1:0] tg, logic [DW-1:0] d);
      cyc();                        // request still pending, ready low
      rf_ready = 1; cyc();
      cyc();                        // waiting, no reply yet
      rsp_valid = 1; rsp_tag = tg; rsp_data = d; cyc();
   endtask

   initial begin
      clr_in();
      m_st = 0; m_pat = 0; m_prm = 0; m_op = 0; m_res = 0;
      m_list = 0; m_la = 0; m_cause = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      phase = "R1 reset state";
      check_outs();

      phase = "R3 normal end";
      scan_start = 1; cyc();
      word_valid = 1; word_tag = 2'b00; word_data = 16'hFFFF; cyc();
      eos_flag = 1; cyc();

      phase = "R4 control word decode";
      scan_start = 1; cyc();
      word_valid = 1; word_tag = 2'b01; word_data = 16'h3257; cyc();

      phase = "R5 address word and no-effect tags";
      scan_start = 1; cyc();
      word_valid = 1; word_tag = 2'b10; word_data = 16'h0ABC; cyc();
      word_valid = 1; word_tag = 2'b11; word_data = 16'hFFFF; cyc();
      word_valid = 1; word_tag = 2'b00; word_data = 16'h1111; cyc();
      eos_flag = 1; cyc();

      phase = "R6 all sources at once, R7 request hold";
      scan_start = 1; cyc();
      event_flag = 1; off_limits = 1; branch_dec = 1; eos_flag = 1;
      word_valid = 1; word_tag = 2'b01; word_data = 16'hAAAA; cyc();
      fetch(2'b01, 16'h1942);       // R8: remote control word, pattern 9 is data-dependent

      phase = "R9 data-dependent scan";
      scan_start = 1; cyc();
      event_flag = 1; eos_flag = 1; word_valid = 1; word_tag = 2'b01; word_data = 16'h5555; cyc();
      cyc();
      branch_dec = 1; cyc();
      fetch(2'b10, 16'h0123);       // R8: remote address word

      phase = "R6 off-limits over branch";
      scan_start = 1; cyc();
      event_flag = 1; off_limits = 1; branch_dec = 1; cyc();
      fetch(2'b01, 16'h0100);

      phase = "R6 branch over control word";
      scan_start = 1; cyc();
      branch_dec = 1; word_valid = 1; word_tag = 2'b01; word_data = 16'h7777; cyc();
      fetch(2'b00, 16'hBEEF);       // R8: data tag reply changes nothing

      phase = "R6 control word over end of scan";
      scan_start = 1; cyc();
      eos_flag = 1; word_valid = 1; word_tag = 2'b01; word_data = 16'h4321; cyc();

      phase = "random";
      void'($urandom(32'd20240611));
      for (int i = 0; i < 5000; i++) begin
         scan_start = ($urandom % 3) == 0;
         word_valid = ($urandom % 2) == 0;
         word_tag   = 2'($urandom);
         word_data  = 16'($urandom);
         eos_flag   = ($urandom % 8) == 0;
         off_limits = ($urandom % 10) == 0;
         branch_dec = ($urandom % 10) == 0;
         event_flag = ($urandom % 12) == 0;
         rf_ready   = ($urandom % 2) == 0;
         rsp_valid  = ($urandom % 3) == 0;
         rsp_tag    = 2'($urandom);
         rsp_data   = 16'($urandom);
         cyc();
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R2 [watchdog] actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule